// File: doc/BRIEF.md
# Branch Condition and Target Unit

This unit resolves one branch request per cycle for a 16-bit processor whose flags are N, Z, C and V. Each request supplies a branch kind, a 4-bit condition code, the current flags, the address of the branch instruction and the operand that matches its kind. The operand is a signed 8-bit halfword offset for a relative branch, a 16-bit address for an absolute branch, or a register value for an indirect branch. The unit decides whether the branch is taken and gives the next fetch address. It also tells the register file whether to write a return address into the link register R6, and which value to write.

The decision is registered. A request presented with `valid_i` high produces its result on the outputs one clock later, with `valid_o` high. Condition 15 has a different meaning for each kind. On the absolute form it is a subroutine call: the branch is taken and the link is written. On the relative form it is illegal: an error flag is raised and no branch is taken. Indirect branches ignore the condition field, and a separate link request turns them into calls. A return is therefore an indirect branch through R6.

Top module: `branch_unit`

## Requirements
- R1: While `rst_ni` is low, and after an asynchronous reset, `valid_o`, `taken_o`, `link_we_o` and `illegal_o` are 0, and `next_pc_o` and `link_val_o` are 0x0000, which is the reset address.
- R2: The outputs show the result of a request one clock after `valid_i` was sampled high, and `valid_o` copies `valid_i` with that same delay. In a cycle after `valid_i` was low, `valid_o`, `taken_o`, `link_we_o` and `illegal_o` are 0, `link_val_o` is 0 and `next_pc_o` keeps its previous value.
- R3: `flags_i` is encoded as bit 3 = N, bit 2 = Z, bit 1 = C, bit 0 = V. Condition codes 0 to 14 pass as follows:
  - 0: Z
  - 1: !Z
  - 2: N^V
  - 3: !(N^V)
  - 4: !Z & !(N^V)
  - 5: Z | (N^V)
  - 6: C
  - 7: !C
  - 8: V
  - 9: !V
  - 10: always
  - 11: C & !Z
  - 12: !C | Z
  - 13: N
  - 14: !N
- R4: A relative branch (`kind_i` = 0) that passes its condition sets `next_pc_o` to `pc_i` plus the sign-extended `rel_off_i` times two, modulo 2^16.
- R5: An absolute branch (`kind_i` = 1) that passes its condition sets `next_pc_o` to `abs_addr_i`.
- R6: An absolute branch with condition 15 is taken whatever the flags are. It sets `next_pc_o` to `abs_addr_i`, sets `link_we_o` to 1, and sets `link_val_o` to `pc_i` + 4.
- R7: A relative branch with condition 15 sets `illegal_o` to 1, is not taken, does not write the link, and sets `next_pc_o` to `pc_i` + 2.
- R8: An indirect branch (`kind_i` = 2) is always taken, whatever `cond_i` and `flags_i` are, and sets `next_pc_o` to `reg_val_i`. When `link_req_i` = 1 it also sets `link_we_o` to 1 and `link_val_o` to `pc_i` + 2.
- R9: A branch whose condition fails is not taken, and `next_pc_o` becomes the fall-through address. This is `pc_i` + 2 for a relative branch and `pc_i` + 4 for an absolute branch.
- R10: `kind_i` = 3 is reserved. It sets `illegal_o` to 1, is not taken, does not link, and sets `next_pc_o` to `pc_i` + 2.
- R11: `link_req_i` has no effect on relative and absolute branches. `link_we_o` is high only together with `taken_o`. `link_val_o` is 0 whenever `link_we_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | A branch request is present this cycle |
| kind_i | input | 2 | Branch kind: 0 relative, 1 absolute, 2 indirect, 3 reserved |
| cond_i | input | 4 | Condition code |
| flags_i | input | 4 | Flags N, Z, C, V (bit 3 down to bit 0) |
| pc_i | input | 16 | Address of the branch instruction |
| rel_off_i | input | 8 | Signed halfword offset for a relative branch |
| abs_addr_i | input | 16 | Target for an absolute branch |
| reg_val_i | input | 16 | Register value used as the target of an indirect branch |
| link_req_i | input | 1 | Link request for an indirect branch |
| valid_o | output | 1 | A result is present |
| taken_o | output | 1 | The branch is taken |
| next_pc_o | output | 16 | Next fetch address |
| link_we_o | output | 1 | Write `link_val_o` to R6 |
| link_val_o | output | 16 | Return address |
| illegal_o | output | 1 | Illegal branch encoding |

## Verification
The only internal state is the single output register stage, so a fault inside the unit shows up on the ports in the cycle right after the request that exposes it. A wrong flag term in the condition logic shows up as a wrong `taken_o` for some combination of condition code and flags. The bench therefore drives all 240 combinations of codes 0 to 14 and flag values. A wrong sign extension, shift or instruction length shows up in `next_pc_o` or `link_val_o`. Vectors that wrap around address 0 and use the largest offsets in both directions expose these faults. A wrong decode of condition 15 shows up as a missing link write or a missing illegal flag.

// File: rtl/branch_unit_pkg.sv
package branch_unit_pkg;
  typedef enum logic [1:0] {
    BK_REL = 2'd0,
    BK_ABS = 2'd1,
    BK_IND = 2'd2,
    BK_RSV = 2'd3
  } br_kind_e;

  typedef struct packed {
    logic n;
    logic z;
    logic c;
    logic v;
  } flags_t;

  localparam logic [3:0] CC_EQ  = 4'd0;
  localparam logic [3:0] CC_NE  = 4'd1;
  localparam logic [3:0] CC_LT  = 4'd2;
  localparam logic [3:0] CC_GE  = 4'd3;
  localparam logic [3:0] CC_GT  = 4'd4;
  localparam logic [3:0] CC_LE  = 4'd5;
  localparam logic [3:0] CC_CS  = 4'd6;
  localparam logic [3:0] CC_CC  = 4'd7;
  localparam logic [3:0] CC_VS  = 4'd8;
  localparam logic [3:0] CC_VC  = 4'd9;
  localparam logic [3:0] CC_AL  = 4'd10;
  localparam logic [3:0] CC_HI  = 4'd11;
  localparam logic [3:0] CC_LS  = 4'd12;
  localparam logic [3:0] CC_MI  = 4'd13;
  localparam logic [3:0] CC_PL  = 4'd14;
  localparam logic [3:0] CC_SUB = 4'd15;
endpackage

// File: rtl/bu_cond_eval.sv
module bu_cond_eval
  import branch_unit_pkg::*;
(
  input  logic [3:0] cond_i,
  input  flags_t     flags_i,
  output logic       pass_o,
  output logic       call_o
);
  logic lt;
  assign lt = flags_i.n ^ flags_i.v;

  always_comb begin
    pass_o = 1'b0;
    case (cond_i)
      CC_EQ:   pass_o = flags_i.z;
      CC_NE:   pass_o = !flags_i.z;
      CC_LT:   pass_o = lt;
      CC_GE:   pass_o = !lt;
      CC_GT:   pass_o = !flags_i.z && !lt;
      CC_LE:   pass_o = flags_i.z || lt;
      CC_CS:   pass_o = flags_i.c;
      CC_CC:   pass_o = !flags_i.c;
      CC_VS:   pass_o = flags_i.v;
      CC_VC:   pass_o = !flags_i.v;
      CC_AL:   pass_o = 1'b1;
      CC_HI:   pass_o = flags_i.c && !flags_i.z;
      CC_LS:   pass_o = !flags_i.c || flags_i.z;
      CC_MI:   pass_o = flags_i.n;
      CC_PL:   pass_o = !flags_i.n;
      default: pass_o = 1'b0; // code 15 is resolved per kind
    endcase
  end

  assign call_o = (cond_i == CC_SUB);
endmodule

// File: rtl/bu_target_calc.sv
module bu_target_calc
  import branch_unit_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int OFF_W  = 8
) (
  input  br_kind_e          kind_i,
  input  logic [ADDR_W-1:0] pc_i,
  input  logic [OFF_W-1:0]  rel_off_i,
  input  logic [ADDR_W-1:0] abs_addr_i,
  input  logic [ADDR_W-1:0] reg_val_i,
  output logic [ADDR_W-1:0] target_o,
  output logic [ADDR_W-1:0] fall_o
);
  localparam int EXT_W = ADDR_W - OFF_W - 1;
  localparam logic [ADDR_W-1:0] SHORT_LEN = ADDR_W'(2);
  localparam logic [ADDR_W-1:0] LONG_LEN  = ADDR_W'(4);

  logic [ADDR_W-1:0] rel_disp;
  assign rel_disp = {{EXT_W{rel_off_i[OFF_W-1]}}, rel_off_i, 1'b0};

  always_comb begin
    case (kind_i)
      BK_REL:  target_o = pc_i + rel_disp;
      BK_ABS:  target_o = abs_addr_i;
      BK_IND:  target_o = reg_val_i;
      default: target_o = pc_i + SHORT_LEN;
    endcase
    fall_o = pc_i + ((kind_i == BK_ABS) ? LONG_LEN : SHORT_LEN);
  end
endmodule

// File: rtl/bu_decide.sv
module bu_decide
  import branch_unit_pkg::*;
(
  input  br_kind_e kind_i,
  input  logic     pass_i,
  input  logic     call_i,
  input  logic     link_req_i,
  output logic     take_o,
  output logic     link_o,
  output logic     illegal_o
);
  always_comb begin
    take_o    = 1'b0;
    link_o    = 1'b0;
    illegal_o = 1'b0;
    case (kind_i)
      BK_REL: begin
        take_o    = pass_i && !call_i;
        illegal_o = call_i;
      end
      BK_ABS: begin
        take_o = pass_i || call_i;
        link_o = call_i;
      end
      BK_IND: begin
        take_o = 1'b1;
        link_o = link_req_i;
      end
      default: illegal_o = 1'b1;
    endcase
  end
endmodule

// File: rtl/branch_unit.sv
module branch_unit
  import branch_unit_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int OFF_W  = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              valid_i,
  input  logic [1:0]        kind_i,
  input  logic [3:0]        cond_i,
  input  logic [3:0]        flags_i,
  input  logic [ADDR_W-1:0] pc_i,
  input  logic [OFF_W-1:0]  rel_off_i,
  input  logic [ADDR_W-1:0] abs_addr_i,
  input  logic [ADDR_W-1:0] reg_val_i,
  input  logic              link_req_i,
  output logic              valid_o,
  output logic              taken_o,
  output logic [ADDR_W-1:0] next_pc_o,
  output logic              link_we_o,
  output logic [ADDR_W-1:0] link_val_o,
  output logic              illegal_o
);
  br_kind_e          kind;
  logic              pass, call, take, link, ill;
  logic [ADDR_W-1:0] target, fall;

  assign kind = br_kind_e'(kind_i);

  bu_cond_eval u_cond (
    .cond_i (cond_i),
    .flags_i(flags_t'(flags_i)),
    .pass_o (pass),
    .call_o (call)
  );

  bu_target_calc #(.ADDR_W(ADDR_W), .OFF_W(OFF_W)) u_tgt (
    .kind_i    (kind),
    .pc_i      (pc_i),
    .rel_off_i (rel_off_i),
    .abs_addr_i(abs_addr_i),
    .reg_val_i (reg_val_i),
    .target_o  (target),
    .fall_o    (fall)
  );

  bu_decide u_dec (
    .kind_i    (kind),
    .pass_i    (pass),
    .call_i    (call),
    .link_req_i(link_req_i),
    .take_o    (take),
    .link_o    (link),
    .illegal_o (ill)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o    <= 1'b0;
      taken_o    <= 1'b0;
      next_pc_o  <= '0;
      link_we_o  <= 1'b0;
      link_val_o <= '0;
      illegal_o  <= 1'b0;
    end else begin
      valid_o <= valid_i;
      if (valid_i) begin
        taken_o    <= take;
        next_pc_o  <= take ? target : fall;
        link_we_o  <= link;
        link_val_o <= link ? fall : '0;
        illegal_o  <= ill;
      end else begin
        taken_o    <= 1'b0;
        link_we_o  <= 1'b0;
        link_val_o <= '0;
        illegal_o  <= 1'b0;
      end
    end
  end

  assert_valid_follows_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |=> valid_o);
  assert_idle_quiet_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> (!valid_o && !taken_o && !link_we_o && !illegal_o));
  assert_idle_hold_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> $stable(next_pc_o));
  assert_illegal_no_branch_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    illegal_o |-> (!taken_o && !link_we_o));
  assert_link_needs_taken_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    link_we_o |-> taken_o);
  assert_link_val_clear_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !link_we_o |-> (link_val_o == '0));
  assert_call_links_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && kind_i == 2'd1 && cond_i == 4'd15) |=> (taken_o && link_we_o));
endmodule

// File: tb/tb_branch_unit.sv
`timescale 1ns/1ps
module tb_branch_unit;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        valid_i = 1'b0;
  logic [1:0]  kind_i = '0;
  logic [3:0]  cond_i = '0;
  logic [3:0]  flags_i = '0;
  logic [15:0] pc_i = '0;
  logic [7:0]  rel_off_i = '0;
  logic [15:0] abs_addr_i = '0;
  logic [15:0] reg_val_i = '0;
  logic        link_req_i = 1'b0;
  logic        valid_o, taken_o, link_we_o, illegal_o;
  logic [15:0] next_pc_o, link_val_o;

  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  branch_unit dut (
    .clk_i(clk), .rst_ni(rst_ni), .valid_i(valid_i), .kind_i(kind_i),
    .cond_i(cond_i), .flags_i(flags_i), .pc_i(pc_i), .rel_off_i(rel_off_i),
    .abs_addr_i(abs_addr_i), .reg_val_i(reg_val_i), .link_req_i(link_req_i),
    .valid_o(valid_o), .taken_o(taken_o), .next_pc_o(next_pc_o),
    .link_we_o(link_we_o), .link_val_o(link_val_o), .illegal_o(illegal_o)
  );

  typedef struct packed {
    logic [1:0]  kind;
    logic [3:0]  cond;
    logic [3:0]  flags;
    logic [15:0] pc;
    logic [7:0]  off;
    logic [15:0] abs_a;
    logic [15:0] rv;
    logic        lreq;
    logic        e_tk;
    logic [15:0] e_next;
    logic        e_lwe;
    logic [15:0] e_lval;
    logic        e_ill;
  } vec_t;

  localparam int NV = 16;
  localparam vec_t VECS [NV] = '{
    '{2'd0, 4'd0,  4'b0100, 16'h0100, 8'h10, 16'h0000, 16'h0000, 1'b0, 1'b1, 16'h0120, 1'b0, 16'h0000, 1'b0}, // R4 EQ taken
    '{2'd0, 4'd0,  4'b0000, 16'h0100, 8'h10, 16'h0000, 16'h0000, 1'b0, 1'b0, 16'h0102, 1'b0, 16'h0000, 1'b0}, // R9 rel fall
    '{2'd0, 4'd10, 4'b0000, 16'h0200, 8'hF0, 16'h0000, 16'h0000, 1'b0, 1'b1, 16'h01E0, 1'b0, 16'h0000, 1'b0}, // R4 negative
    '{2'd0, 4'd10, 4'b0000, 16'h0010, 8'h80, 16'h0000, 16'h0000, 1'b1, 1'b1, 16'hFF10, 1'b0, 16'h0000, 1'b0}, // R4 wrap low, R11 lreq
    '{2'd0, 4'd10, 4'b0000, 16'hFFF0, 8'h7F, 16'h0000, 16'h0000, 1'b0, 1'b1, 16'h00EE, 1'b0, 16'h0000, 1'b0}, // R4 wrap high
    '{2'd1, 4'd1,  4'b0000, 16'h0300, 8'h00, 16'h1234, 16'h0000, 1'b0, 1'b1, 16'h1234, 1'b0, 16'h0000, 1'b0}, // R5 NE taken
    '{2'd1, 4'd1,  4'b0100, 16'h0300, 8'h00, 16'h1234, 16'h0000, 1'b0, 1'b0, 16'h0304, 1'b0, 16'h0000, 1'b0}, // R9 abs fall
    '{2'd1, 4'd15, 4'b0101, 16'h0400, 8'h00, 16'h2000, 16'h0000, 1'b0, 1'b1, 16'h2000, 1'b1, 16'h0404, 1'b0}, // R6 call
    '{2'd0, 4'd15, 4'b0000, 16'h0500, 8'h04, 16'h0000, 16'h0000, 1'b0, 1'b0, 16'h0502, 1'b0, 16'h0000, 1'b1}, // R7 illegal
    '{2'd2, 4'd0,  4'b0000, 16'h0600, 8'h00, 16'h0000, 16'h4444, 1'b0, 1'b1, 16'h4444, 1'b0, 16'h0000, 1'b0}, // R8 no link
    '{2'd2, 4'd3,  4'b1000, 16'h0600, 8'h00, 16'h0000, 16'h0ABC, 1'b1, 1'b1, 16'h0ABC, 1'b1, 16'h0602, 1'b0}, // R8 link
    '{2'd1, 4'd10, 4'b0000, 16'h0700, 8'h00, 16'h0800, 16'h0000, 1'b1, 1'b1, 16'h0800, 1'b0, 16'h0000, 1'b0}, // R11 abs lreq
    '{2'd3, 4'd10, 4'b0000, 16'h0900, 8'h05, 16'h1111, 16'h2222, 1'b1, 1'b0, 16'h0902, 1'b0, 16'h0000, 1'b1}, // R10 reserved
    '{2'd0, 4'd11, 4'b0010, 16'h1000, 8'h01, 16'h0000, 16'h0000, 1'b0, 1'b1, 16'h1002, 1'b0, 16'h0000, 1'b0}, // R3 HI
    '{2'd1, 4'd2,  4'b1000, 16'h1100, 8'h00, 16'h0050, 16'h0000, 1'b0, 1'b1, 16'h0050, 1'b0, 16'h0000, 1'b0}, // R3 LT
    '{2'd2, 4'd15, 4'b0000, 16'h1200, 8'h00, 16'h0000, 16'h0002, 1'b0, 1'b1, 16'h0002, 1'b0, 16'h0000, 1'b0}  // R8 cond ignored
  };

  task automatic chk(input string req, input string what, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  function automatic logic ref_pass(input logic [3:0] cc, input logic [3:0] f);
    logic n, z, c, v;
    {n, z, c, v} = f;
    case (cc)
      4'd0:  return z;
      4'd1:  return !z;
      4'd2:  return n != v;
      4'd3:  return n == v;
      4'd4:  return !z && (n == v);
      4'd5:  return z || (n != v);
      4'd6:  return c;
      4'd7:  return !c;
      4'd8:  return v;
      4'd9:  return !v;
      4'd10: return 1'b1;
      4'd11: return c && !z;
      4'd12: return !c || z;
      4'd13: return n;
      4'd14: return !n;
      default: return 1'b0;
    endcase
  endfunction

  task automatic drive(input vec_t t);
    @(negedge clk);
    valid_i = 1'b1; kind_i = t.kind; cond_i = t.cond; flags_i = t.flags;
    pc_i = t.pc; rel_off_i = t.off; abs_addr_i = t.abs_a; reg_val_i = t.rv;
    link_req_i = t.lreq;
    @(negedge clk);
  endtask

  initial begin
    #(5.0 * 150000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    vec_t t;
    logic [15:0] held;
    repeat (3) @(negedge clk);
    // R1: state under reset
    chk("R1", "valid_o", 16'(valid_o), 16'h0);
    chk("R1", "taken_o", 16'(taken_o), 16'h0);
    chk("R1", "next_pc_o", next_pc_o, 16'h0000);
    chk("R1", "link", {link_val_o[14:0], link_we_o}, 16'h0);
    chk("R1", "illegal_o", 16'(illegal_o), 16'h0);
    rst_ni = 1'b1;

    for (int i = 0; i < NV; i++) begin
      drive(VECS[i]);
      chk("R2", "valid_o", 16'(valid_o), 16'h1);
      chk("R3-table taken", "taken_o", 16'(taken_o), 16'(VECS[i].e_tk));
      chk("R4/R5 next", "next_pc_o", next_pc_o, VECS[i].e_next);
      chk("R6/R8/R11 link_we", "link_we_o", 16'(link_we_o), 16'(VECS[i].e_lwe));
      chk("R6/R8/R11 link_val", "link_val_o", link_val_o, VECS[i].e_lval);
      chk("R7/R10 illegal", "illegal_o", 16'(illegal_o), 16'(VECS[i].e_ill));
    end

    // R2: idle cycle holds next_pc and clears strobes
    held = next_pc_o;
    valid_i = 1'b0;
    kind_i = 2'd1; cond_i = 4'd15; abs_addr_i = 16'h7777;
    @(negedge clk);
    chk("R2", "valid_o idle", 16'(valid_o), 16'h0);
    chk("R2", "taken_o idle", 16'(taken_o), 16'h0);
    chk("R2", "link_we_o idle", 16'(link_we_o), 16'h0);
    chk("R2", "next_pc_o held", next_pc_o, held);

    // R3: every code 0..14 against every flag value
    for (int cc = 0; cc < 15; cc++) begin
      for (int f = 0; f < 16; f++) begin
        t = '0;
        t.kind = 2'd0; t.cond = 4'(cc); t.flags = 4'(f);
        t.pc = 16'h2000; t.off = 8'h02;
        drive(t);
        chk("R3", $sformatf("taken cc=%0d f=%b", cc, f[3:0]), 16'(taken_o),
            16'(ref_pass(4'(cc), 4'(f))));
        chk("R9", "next_pc_o", next_pc_o,
            ref_pass(4'(cc), 4'(f)) ? 16'h2004 : 16'h2002);
      end
    end

    // R6: call taken for every flag value
    for (int f = 0; f < 16; f++) begin
      t = '0;
      t.kind = 2'd1; t.cond = 4'd15; t.flags = 4'(f);
      t.pc = 16'hFFFE; t.abs_a = 16'h0040;
      drive(t);
      chk("R6", "taken_o", 16'(taken_o), 16'h1);
      chk("R6", "link_val_o wrap", link_val_o, 16'h0002);
    end

    // R1: asynchronous reset mid-run
    valid_i = 1'b0;
    #1 rst_ni = 1'b0;
    #1;
    chk("R1", "next_pc_o after reset", next_pc_o, 16'h0000);
    chk("R1", "valid_o after reset", 16'(valid_o), 16'h0);
    chk("R1", "link_val_o after reset", link_val_o, 16'h0000);
    @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule